// File: doc/BRIEF.md
# All-Bank Refresh Sequencer

This block drives periodic refresh across a group of DRAM banks. It holds a due time and compares it with a free-running cycle count supplied from outside. When the count reaches the due time, the block enters a drain phase. In that phase it requests a precharge for every bank that still holds an open row. Each request is raised no earlier than that bank's own earliest-precharge time.

The refresh is issued only after every open bank has been closed and the row-precharge time of the last close has elapsed. At that point the block pulses the refresh command and raises the power state to refresh. It also broadcasts one activate-block time to all banks, equal to the issue cycle plus the refresh cycle time.

The next due time is one refresh interval after the previous due time, not after the refresh actually finished. A late refresh therefore pulls the following one forward. If a refresh finishes later than one interval past its due time, a sticky overrun error is raised. The power state drops back to idle once the completion cycle is reached.

Top module: `allbank_refresh_seq`

## Requirements
- R1: During drain, each bank whose open flag is 1 gets exactly one single-cycle precharge request. The request comes in the first cycle where the cycle count is at least that bank's earliest-precharge time. A bank whose open flag is 0 gets none.
- R2: The refresh command is a single-cycle pulse. It is issued only once all open banks have had their precharge request and the cycle count has reached the last request's cycle plus T_RP. If no bank is open, it is issued in the cycle after drain starts.
- R3: In the refresh issue cycle, the activate-block write strobe pulses and the broadcast time equals the issue cycle count plus T_RFC.
- R4: The overrun error rises when the due time plus T_REFI is less than the refresh completion time. Once set, it stays set until reset.
- R5: The first due time is T_REFI. Each refresh moves the due time forward by exactly T_REFI from the previous due time, regardless of when the refresh completed.
- R6: The power state reads 1 (refresh) from the issue cycle up to the cycle where the count reaches the completion time, and reads 0 (idle) there. It stays 0 during drain.
- R7: After reset, all precharge requests, the refresh command, the write strobe, the power state and the overrun error are 0.
- R8: No drain or refresh starts before the cycle count reaches the due time. Drain begins in the cycle in which the count is at least the due time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_cycle | input | TIME_W | Current cycle count |
| bank_open | input | NUM_BANKS | 1 where a bank holds an open row |
| bank_pre_allowed | input | NUM_BANKS*TIME_W | Earliest precharge cycle per bank, bank b in slice b |
| pre_req | output | NUM_BANKS | One-cycle precharge request per bank |
| ref_cmd | output | 1 | One-cycle refresh command |
| act_block_we | output | 1 | Strobe to write the activate-block time into all banks |
| act_block_at | output | TIME_W | Earliest activate cycle after refresh |
| pwr_state | output | 1 | 0 idle, 1 refresh |
| overrun_err | output | 1 | Sticky refresh overrun |

## Verification
The first pattern has every bank closed. It isolates the due-time comparison and the shortest path to refresh. It also fixes the baseline completion time and the return to idle.

The second pattern mixes open banks whose earliest-precharge times lie before and after the due time with closed banks that carry small earliest-precharge times. This tells apart precharging at the later of the two times, ignoring closed banks, and waiting the row-precharge time after the last close.

The third pattern holds one bank's precharge far past the interval. This forces an overrun and shows the following refresh arriving soon after the late one. A design that re-anchors the due time to completion would place that refresh a full interval later.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_DRAIN   = 2'd1,
    SEQ_REFRESH = 2'd2
  } seq_state_e;

  localparam logic PWR_IDLE = 1'b0;
  localparam logic PWR_REF  = 1'b1;
endpackage

// File: rtl/refseq_due_timer.sv
module refseq_due_timer #(
  parameter int TIME_W = 32,
  parameter int T_REFI = 7800,
  parameter int T_RFC  = 260
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now,
  input  logic              advance,
  output logic              due_hit,
  output logic              overrun
);
  localparam logic [TIME_W:0] REFI_W = (TIME_W+1)'(T_REFI);
  localparam logic [TIME_W:0] RFC_W  = (TIME_W+1)'(T_RFC);

  logic [TIME_W-1:0] due_q;
  logic [TIME_W:0]   limit;
  logic [TIME_W:0]   finish;

  assign due_hit = (now >= due_q);
  assign limit   = {1'b0, due_q} + REFI_W;
  assign finish  = {1'b0, now} + RFC_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      due_q   <= TIME_W'(T_REFI);
      overrun <= 1'b0;
    end else if (advance) begin
      due_q <= due_q + TIME_W'(T_REFI);
      if (limit < finish) overrun <= 1'b1;
    end
  end

  AST_DUE_STEP: assert property (@(posedge clk) disable iff (rst)
    advance |=> (due_q == $past(due_q) + TIME_W'(T_REFI))); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun); // R4
endmodule

// File: rtl/refseq_bank_closer.sv
module refseq_bank_closer #(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 32,
  parameter int T_RP      = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        active,
  input  logic [TIME_W-1:0]           now,
  input  logic [NUM_BANKS-1:0]        bank_open,
  input  logic [NUM_BANKS*TIME_W-1:0] pre_allowed,
  output logic [NUM_BANKS-1:0]        pre_req,
  output logic                        all_closed
);
  logic [NUM_BANKS-1:0] issued_q;
  logic [NUM_BANKS-1:0] fire;
  logic [TIME_W-1:0]    drain_until_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TIME_W-1:0] allowed;
    assign allowed = pre_allowed[b*TIME_W +: TIME_W];
    assign fire[b] = active && bank_open[b] && !issued_q[b] && (now >= allowed);

    AST_PRE_AFTER_ALLOWED: assert property (@(posedge clk) disable iff (rst)
      pre_req[b] |-> ($past(now) >= $past(allowed))); // R1
    AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      pre_req[b] |=> !pre_req[b]); // R1
  end

  assign all_closed = ((bank_open & ~issued_q) == '0) && (now >= drain_until_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      issued_q      <= '0;
      drain_until_q <= '0;
      pre_req       <= '0;
    end else begin
      pre_req <= fire;
      if (start) begin
        issued_q      <= '0;
        drain_until_q <= '0;
      end else begin
        issued_q <= issued_q | fire;
        if (|fire) drain_until_q <= now + TIME_W'(T_RP);
      end
    end
  end
endmodule

// File: rtl/allbank_refresh_seq.sv
module allbank_refresh_seq
  import refseq_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 32,
  parameter int T_REFI    = 7800,
  parameter int T_RFC     = 260,
  parameter int T_RP      = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TIME_W-1:0]           now_cycle,
  input  logic [NUM_BANKS-1:0]        bank_open,
  input  logic [NUM_BANKS*TIME_W-1:0] bank_pre_allowed,
  output logic [NUM_BANKS-1:0]        pre_req,
  output logic                        ref_cmd,
  output logic                        act_block_we,
  output logic [TIME_W-1:0]           act_block_at,
  output logic                        pwr_state,
  output logic                        overrun_err
);
  seq_state_e        state_q;
  logic [TIME_W-1:0] done_at_q;
  logic              due_hit;
  logic              all_closed;
  logic              start_drain;
  logic              issue_ref;

  assign start_drain = (state_q == SEQ_IDLE) && due_hit;
  assign issue_ref   = (state_q == SEQ_DRAIN) && all_closed;

  refseq_due_timer #(
    .TIME_W(TIME_W), .T_REFI(T_REFI), .T_RFC(T_RFC)
  ) u_due (
    .clk(clk), .rst(rst), .now(now_cycle), .advance(issue_ref),
    .due_hit(due_hit), .overrun(overrun_err)
  );

  refseq_bank_closer #(
    .NUM_BANKS(NUM_BANKS), .TIME_W(TIME_W), .T_RP(T_RP)
  ) u_close (
    .clk(clk), .rst(rst), .start(start_drain),
    .active(state_q == SEQ_DRAIN), .now(now_cycle),
    .bank_open(bank_open), .pre_allowed(bank_pre_allowed),
    .pre_req(pre_req), .all_closed(all_closed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_IDLE;
      done_at_q    <= '0;
      ref_cmd      <= 1'b0;
      act_block_we <= 1'b0;
      act_block_at <= '0;
      pwr_state    <= PWR_IDLE;
    end else begin
      ref_cmd      <= 1'b0;
      act_block_we <= 1'b0;
      case (state_q)
        SEQ_IDLE: if (start_drain) state_q <= SEQ_DRAIN;
        SEQ_DRAIN: if (issue_ref) begin
          ref_cmd      <= 1'b1;
          act_block_we <= 1'b1;
          act_block_at <= now_cycle + TIME_W'(T_RFC);
          done_at_q    <= now_cycle + TIME_W'(T_RFC);
          pwr_state    <= PWR_REF;
          state_q      <= SEQ_REFRESH;
        end
        SEQ_REFRESH: if (now_cycle >= done_at_q) begin
          pwr_state <= PWR_IDLE;
          state_q   <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_REF_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> $past(all_closed)); // R2
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |=> !ref_cmd); // R2
  AST_BLOCK_TIME: assert property (@(posedge clk) disable iff (rst)
    act_block_we |-> (act_block_at == $past(now_cycle) + TIME_W'(T_RFC))); // R3
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_state) |-> ($past(now_cycle) >= act_block_at)); // R6
  AST_PWR_WITH_REF: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> (pwr_state == PWR_REF)); // R6
endmodule

// File: tb/allbank_refresh_seq_test.sv
module allbank_refresh_seq_test;
  localparam int NB = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] now = '0;
  logic [NB-1:0] bank_open = '0;
  logic [NB*TW-1:0] pre_allowed = '0;
  logic [NB-1:0] pre_req;
  logic          ref_cmd, act_block_we, pwr_state, overrun_err;
  logic [TW-1:0] act_block_at;

  int checks = 0, fails = 0;
  int ref_t[8], blk_v[8], idle_t[8];
  int nref = 0, nblk = 0, nidle = 0;
  int pre_t[NB], pre_n[NB];
  logic pwr_prev = 1'b0;

  allbank_refresh_seq #(.NUM_BANKS(NB), .TIME_W(TW), .T_REFI(200),
    .T_RFC(20), .T_RP(4)) uut (
    .clk(clk), .rst(rst), .now_cycle(now), .bank_open(bank_open),
    .bank_pre_allowed(pre_allowed), .pre_req(pre_req), .ref_cmd(ref_cmd),
    .act_block_we(act_block_we), .act_block_at(act_block_at),
    .pwr_state(pwr_state), .overrun_err(overrun_err));

  always #5 clk = ~clk;
  always @(negedge clk) if (!rst) now <= now + 1'b1;

  initial begin
    for (int b = 0; b < NB; b++) begin pre_t[b] = -1; pre_n[b] = 0; end
  end

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (ref_cmd && nref < 8) begin ref_t[nref] = int'(now); nref++; end
      if (act_block_we && nblk < 8) begin blk_v[nblk] = int'(act_block_at); nblk++; end
      if (pwr_prev && !pwr_state && nidle < 8) begin idle_t[nidle] = int'(now); nidle++; end
      pwr_prev = pwr_state;
      for (int b = 0; b < NB; b++)
        if (pre_req[b]) begin pre_t[b] = int'(now); pre_n[b]++; bank_open[b] = 1'b0; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_now(input int t);
    while (int'(now) < t) begin @(posedge clk); #2; end
  endtask

  task automatic test_reset;
    repeat (3) @(posedge clk);
    #2;
    chk("R7 pre_req", int'(pre_req), 0);
    chk("R7 ref_cmd", int'(ref_cmd), 0);
    chk("R7 act_block_we", int'(act_block_we), 0);
    chk("R7 pwr_state", int'(pwr_state), 0);
    chk("R7 overrun", int'(overrun_err), 0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic test_all_closed;
    wait_now(199);
    chk("R8 no refresh before due", nref, 0);
    wait_now(205);
    chk("R2 refresh cycle with no open bank", ref_t[0], 201);
    chk("R3 activate block time", blk_v[0], 221);
    chk("R6 power refresh", int'(pwr_state), 1);
    wait_now(230);
    chk("R6 idle at completion", idle_t[0], 221);
    chk("R4 no overrun", int'(overrun_err), 0);
  endtask

  task automatic test_drain;
    @(negedge clk);
    pre_allowed[0*TW +: TW] = 16'd390;
    pre_allowed[1*TW +: TW] = 16'd5;
    pre_allowed[2*TW +: TW] = 16'd410;
    pre_allowed[3*TW +: TW] = 16'd0;
    bank_open = 4'b0101;
    wait_now(405);
    chk("R1 bank0 precharged at now", pre_t[0], 401);
    chk("R6 idle during drain", int'(pwr_state), 0);
    wait_now(413);
    chk("R2 no refresh before last close plus tRP", nref, 1);
    wait_now(440);
    chk("R1 bank2 precharged at its allowed time", pre_t[2], 410);
    chk("R1 closed bank1 ignored", pre_n[1], 0);
    chk("R1 closed bank3 ignored", pre_n[3], 0);
    chk("R1 bank0 single request", pre_n[0], 1);
    chk("R2 refresh after drain", ref_t[1], 414);
    chk("R3 activate block time", blk_v[1], 434);
    chk("R6 idle at completion", idle_t[1], 434);
  endtask

  task automatic test_overrun;
    @(negedge clk);
    pre_allowed[1*TW +: TW] = 16'd800;
    bank_open = 4'b0010;
    wait_now(700);
    chk("R4 overrun clear while waiting", int'(overrun_err), 0);
    chk("R5 one refresh per interval", nref, 2);
    wait_now(830);
    chk("R1 late bank precharge", pre_t[1], 800);
    chk("R2 late refresh", ref_t[2], 804);
    chk("R4 overrun raised", int'(overrun_err), 1);
    chk("R6 idle after late refresh", idle_t[2], 824);
    chk("R5 next due anchored to previous due", ref_t[3], 826);
    wait_now(998);
    chk("R4 overrun sticky", int'(overrun_err), 1);
    chk("R8 no refresh before due 1000", nref, 4);
    wait_now(1005);
    chk("R5 due advanced by interval", ref_t[4], 1001);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_all_closed();
        test_drain();
        test_overrun();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule